// File: doc/BRIEF.md
# Multi-Channel DAC Serial Register Slave

This block is the digital control side of a multi-channel digital-to-analog converter. A host talks to it through a four-wire serial port. Each access is one 24-bit frame, sent while chip select is low. The block decodes the frame into a 2-bit command, a 6-bit address and a 16-bit data word. It then updates one of three registers per channel (the input code, an offset trim or a gain trim) or one entry of a small special-function space. That space holds a power-down control, one coarse offset register for each voltage reference, and a readback selector.

Reading is split across two frames. The first frame writes the readback selector with a source type and a register address. The second frame, whatever it carries, shifts the selected 16-bit value out on MISO. The block drives the per-channel codes, the coarse offset that applies to each channel and the power-down flag to the analog side as plain outputs.

The serial pins are sampled with the block's own clock, so that clock must run at least eight times faster than SCLK. The serial port cannot be stalled, so no port has back-pressure. A frame is acted on exactly once, when chip select rises, and the outputs are plain levels that hold their value until the next frame that changes them.

Top module: `dac_spi_regs`

## Requirements
- R1: A frame is MSB first: bit 23 is clocked in on the first rising SCLK edge, with bits 23:22 = command, 21:16 = address and 15:0 = data. It takes effect when chip select rises only if exactly 24 rising edges were seen. A frame of any other length changes no register.
- R2: Command 3 to address 8+n (n < NUM_CH) loads the input code of channel n. Data bits below the top CODE_W bits are stored as zero. The code appears on `ch_code[16n +: 16]`.
- R3: Command 2 to address 8+n loads the offset trim of channel n, and command 1 loads its gain trim. Both use the same masking of the low bits as R2.
- R4: A command 1, 2 or 3 to an address below 8 or at or above 8+NUM_CH leaves every register unchanged.
- R5: Command 0 to address 1 sets `pwr_down` from data bit 0. The other data bits are ignored.
- R6: Command 0 to address 2+k loads coarse offset register k from data bits 13:0, for k < NUM_REF. Addresses 2+k with k >= NUM_REF, and address 0, change nothing.
- R7: Channel n takes coarse offset register min(n / CH_PER_GRP, NUM_REF-1), and drives it on `ch_offset_base[14n +: 14]`.
- R8: Command 0 to address 5 arms a readback, with data bits 15:13 = source type and bits 12:7 = register address. During the next chip-select window, MISO shifts out a 24-bit word whose top 8 bits are zero and whose low 16 bits are the selected value, MSB first. Each bit is updated after a rising SCLK edge, so that bit 23 is valid after the first rising edge.
- R9: Source type 0 and type 1 both return the channel input code, 2 returns the offset trim, 3 returns the gain trim, and 4 returns a special-function register (address 1 = power-down in bit 0, 2+k = coarse offset k, zero-extended). Types 5 to 7, or an address with no register behind it, return 0.
- R10: MISO is low whenever no readback is armed. An armed readback is used up by the next chip-select window of any length.
- R11: After reset, all input codes, offset trims and coarse offsets are zero, gain trims are all ones in their kept bits, and `pwr_down` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low chip select framing one access |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial readback data out of the block |
| pwr_down | output | 1 | Power-down request to the analog side |
| ch_code | output | NUM_CH*16 | Input code of every channel, channel n at bits 16n+15:16n |
| ch_offset_base | output | NUM_CH*14 | Coarse offset that applies to each channel, channel n at bits 14n+13:14n |

## Verification
The hardest case to reach is a readback request followed by a second frame that is itself malformed, or that is itself another request. Only this case shows whether the armed state is used up by a window of the wrong length, and whether back-to-back requests pass the older value out while arming the newer one. The stimulus produces it by sending requests in consecutive frames and by following one with a 10-bit window, then a normal frame whose MISO must stay low. Clamping of the group index for the upper channels is covered as well: a write to the last coarse offset register must move every channel past the last full group.

// File: rtl/dacspi_pkg.sv
package dacspi_pkg;

  localparam int FRAME_W = 24;
  localparam int ADDR_W  = 6;
  localparam int WORD_W  = 16;
  localparam int OFS_W   = 14;
  localparam int CH_BASE = 8;

  localparam logic [ADDR_W-1:0] SF_NOP   = 6'd0;
  localparam logic [ADDR_W-1:0] SF_CTRL  = 6'd1;
  localparam logic [ADDR_W-1:0] SF_GOFS0 = 6'd2;
  localparam logic [ADDR_W-1:0] SF_RBSEL = 6'd5;

  typedef enum logic [1:0] {
    CMD_SPECIAL = 2'd0,
    CMD_GAIN    = 2'd1,
    CMD_OFFSET  = 2'd2,
    CMD_DATA    = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    RB_CODE_A  = 3'd0,
    RB_CODE_B  = 3'd1,
    RB_OFFSET  = 3'd2,
    RB_GAIN    = 3'd3,
    RB_SPECIAL = 3'd4
  } rbsrc_e;

  typedef struct packed {
    cmd_e               cmd;
    logic [ADDR_W-1:0]  addr;
    logic [WORD_W-1:0]  data;
  } frame_t;

  function automatic int grp_index(int ch, int per, int nref);
    int g;
    g = ch / per;
    if (g > nref - 1) g = nref - 1;
    return g;
  endfunction

endpackage

// File: rtl/dac_spi_frame.sv
module dac_spi_frame
  import dacspi_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               cs_n,
  input  logic               mosi,
  input  logic [FRAME_W-1:0] tx_word,
  output frame_t             frame,
  output logic               commit,
  output logic               frame_end,
  output logic               miso
);

  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

  logic [2:0] sclk_p;
  logic [2:0] cs_p;
  logic [1:0] mosi_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
    end else begin
      sclk_p <= {sclk_p[1:0], sclk};
      cs_p   <= {cs_p[1:0], cs_n};
      mosi_p <= {mosi_p[0], mosi};
    end
  end

  logic sclk_rise, cs_fall, cs_rise, selected;
  assign sclk_rise = sclk_p[1] & ~sclk_p[2];
  assign cs_fall   = ~cs_p[1] & cs_p[2];
  assign cs_rise   = cs_p[1] & ~cs_p[2];
  assign selected  = ~cs_p[1];

  logic [FRAME_W-1:0] rx_sh;
  logic [FRAME_W-1:0] tx_sh;
  logic [CNT_W-1:0]   bit_cnt;
  logic               miso_q;
  logic               commit_q;
  logic               end_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh    <= '0;
      tx_sh    <= '0;
      bit_cnt  <= '0;
      miso_q   <= 1'b0;
      commit_q <= 1'b0;
      end_q    <= 1'b0;
    end else begin
      commit_q <= 1'b0;
      end_q    <= 1'b0;
      if (cs_fall) begin
        bit_cnt <= '0;
        tx_sh   <= tx_word;
        miso_q  <= 1'b0;
      end else if (cs_rise) begin
        commit_q <= (bit_cnt == CNT_FULL);
        end_q    <= 1'b1;
        miso_q   <= 1'b0;
      end else if (selected && sclk_rise) begin
        rx_sh  <= {rx_sh[FRAME_W-2:0], mosi_p[1]};
        miso_q <= tx_sh[FRAME_W-1];
        tx_sh  <= {tx_sh[FRAME_W-2:0], 1'b0};
        if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  assign frame     = frame_t'(rx_sh);
  assign commit    = commit_q;
  assign frame_end = end_q;
  assign miso      = miso_q;

endmodule

// File: rtl/dac_chan_bank.sv
module dac_chan_bank
  import dacspi_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CODE_W = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           commit,
  input  frame_t                         frame,
  output logic [NUM_CH-1:0][WORD_W-1:0]  code_q,
  output logic [NUM_CH-1:0][WORD_W-1:0]  offs_q,
  output logic [NUM_CH-1:0][WORD_W-1:0]  gain_q
);

  localparam logic [WORD_W-1:0] KEEP =
    ~((WORD_W'(1) << (WORD_W - CODE_W)) - WORD_W'(1));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic              hit;
    logic [WORD_W-1:0] code_r, offs_r, gain_r;

    assign hit = commit && (frame.addr == ADDR_W'(CH_BASE + i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        code_r <= '0;
        offs_r <= '0;
        gain_r <= KEEP;
      end else if (hit) begin
        case (frame.cmd)
          CMD_DATA:   code_r <= frame.data & KEEP;
          CMD_OFFSET: offs_r <= frame.data & KEEP;
          CMD_GAIN:   gain_r <= frame.data & KEEP;
          default:    ;
        endcase
      end
    end

    assign code_q[i] = code_r;
    assign offs_q[i] = offs_r;
    assign gain_q[i] = gain_r;
  end

endmodule

// File: rtl/dac_special_regs.sv
module dac_special_regs
  import dacspi_pkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int CH_PER_GRP = 8,
  parameter int NUM_REF    = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           commit,
  input  logic                           frame_end,
  input  frame_t                         frame,
  output logic                           pwr_down,
  output logic [NUM_REF-1:0][OFS_W-1:0]  grp_ofs,
  output logic [NUM_CH-1:0][OFS_W-1:0]   ch_ofs,
  output logic                           rb_pending,
  output logic [2:0]                     rb_type,
  output logic [ADDR_W-1:0]              rb_addr
);

  logic sf_write, rb_req;
  assign sf_write = commit && (frame.cmd == CMD_SPECIAL);
  assign rb_req   = sf_write && (frame.addr == SF_RBSEL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_down <= 1'b0;
    end else if (sf_write && frame.addr == SF_CTRL) begin
      pwr_down <= frame.data[0];
    end
  end

  for (genvar k = 0; k < NUM_REF; k++) begin : g_grp
    logic [OFS_W-1:0] ofs_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ofs_r <= '0;
      else if (sf_write && frame.addr == SF_GOFS0 + ADDR_W'(k))
        ofs_r <= frame.data[OFS_W-1:0];
    end
    assign grp_ofs[k] = ofs_r;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_map
    localparam int G = grp_index(i, CH_PER_GRP, NUM_REF);
    assign ch_ofs[i] = grp_ofs[G];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_pending <= 1'b0;
      rb_type    <= '0;
      rb_addr    <= '0;
    end else begin
      if (frame_end) rb_pending <= rb_req;
      if (rb_req) begin
        rb_type <= frame.data[15:13];
        rb_addr <= frame.data[12:7];
      end
    end
  end

endmodule

// File: rtl/dac_readback.sv
module dac_readback
  import dacspi_pkg::*;
#(
  parameter int NUM_CH  = 16,
  parameter int NUM_REF = 2
) (
  input  logic [2:0]                     rb_type,
  input  logic [ADDR_W-1:0]              rb_addr,
  input  logic [NUM_CH-1:0][WORD_W-1:0]  code_q,
  input  logic [NUM_CH-1:0][WORD_W-1:0]  offs_q,
  input  logic [NUM_CH-1:0][WORD_W-1:0]  gain_q,
  input  logic                           pwr_down,
  input  logic [NUM_REF-1:0][OFS_W-1:0]  grp_ofs,
  output logic [WORD_W-1:0]              rb_value
);

  logic [WORD_W-1:0] chan_code, chan_offs, chan_gain, sf_value;

  always_comb begin
    chan_code = '0;
    chan_offs = '0;
    chan_gain = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rb_addr == ADDR_W'(CH_BASE + i)) begin
        chan_code = code_q[i];
        chan_offs = offs_q[i];
        chan_gain = gain_q[i];
      end
    end
  end

  always_comb begin
    sf_value = '0;
    if (rb_addr == SF_CTRL) sf_value = {{(WORD_W-1){1'b0}}, pwr_down};
    for (int k = 0; k < NUM_REF; k++) begin
      if (rb_addr == SF_GOFS0 + ADDR_W'(k))
        sf_value = {{(WORD_W-OFS_W){1'b0}}, grp_ofs[k]};
    end
  end

  always_comb begin
    case (rb_type)
      RB_CODE_A, RB_CODE_B: rb_value = chan_code;
      RB_OFFSET:            rb_value = chan_offs;
      RB_GAIN:              rb_value = chan_gain;
      RB_SPECIAL:           rb_value = sf_value;
      default:              rb_value = '0;
    endcase
  end

endmodule

// File: rtl/dac_spi_regs.sv
module dac_spi_regs
  import dacspi_pkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int CH_PER_GRP = 8,
  parameter int NUM_REF    = 2,
  parameter int CODE_W     = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       spi_sclk,
  input  logic                       spi_cs_n,
  input  logic                       spi_mosi,
  output logic                       spi_miso,
  output logic                       pwr_down,
  output logic [NUM_CH*WORD_W-1:0]   ch_code,
  output logic [NUM_CH*OFS_W-1:0]    ch_offset_base
);

  frame_t                         frame;
  logic                           commit;
  logic                           frame_end;
  logic [FRAME_W-1:0]             tx_word;
  logic [NUM_CH-1:0][WORD_W-1:0]  code_q, offs_q, gain_q;
  logic [NUM_REF-1:0][OFS_W-1:0]  grp_ofs;
  logic [NUM_CH-1:0][OFS_W-1:0]   ch_ofs;
  logic                           rb_pending;
  logic [2:0]                     rb_type;
  logic [ADDR_W-1:0]              rb_addr;
  logic [WORD_W-1:0]              rb_value;

  dac_spi_frame u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk      (spi_sclk),
    .cs_n      (spi_cs_n),
    .mosi      (spi_mosi),
    .tx_word   (tx_word),
    .frame     (frame),
    .commit    (commit),
    .frame_end (frame_end),
    .miso      (spi_miso)
  );

  dac_chan_bank #(
    .NUM_CH (NUM_CH),
    .CODE_W (CODE_W)
  ) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .commit (commit),
    .frame  (frame),
    .code_q (code_q),
    .offs_q (offs_q),
    .gain_q (gain_q)
  );

  dac_special_regs #(
    .NUM_CH     (NUM_CH),
    .CH_PER_GRP (CH_PER_GRP),
    .NUM_REF    (NUM_REF)
  ) u_sf (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (commit),
    .frame_end  (frame_end),
    .frame      (frame),
    .pwr_down   (pwr_down),
    .grp_ofs    (grp_ofs),
    .ch_ofs     (ch_ofs),
    .rb_pending (rb_pending),
    .rb_type    (rb_type),
    .rb_addr    (rb_addr)
  );

  dac_readback #(
    .NUM_CH  (NUM_CH),
    .NUM_REF (NUM_REF)
  ) u_rb (
    .rb_type  (rb_type),
    .rb_addr  (rb_addr),
    .code_q   (code_q),
    .offs_q   (offs_q),
    .gain_q   (gain_q),
    .pwr_down (pwr_down),
    .grp_ofs  (grp_ofs),
    .rb_value (rb_value)
  );

  assign tx_word        = rb_pending ? {{(FRAME_W-WORD_W){1'b0}}, rb_value} : '0;
  assign ch_code        = code_q;
  assign ch_offset_base = ch_ofs;

endmodule

// File: rtl/dac_spi_regs_chk.sv
module dac_spi_regs_chk
  import dacspi_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      commit,
  input logic                      frame_end,
  input logic [1:0]                frame_cmd,
  input logic [ADDR_W-1:0]         frame_addr,
  input logic                      rb_pending,
  input logic                      miso,
  input logic                      pwr_down,
  input logic [NUM_CH*WORD_W-1:0]  ch_code,
  input logic [NUM_CH*OFS_W-1:0]   ch_ofs
);

  p_commit_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

  p_commit_at_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> frame_end);

  p_code_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ch_code) |-> $past(commit) && $past(frame_cmd) != 2'd0);

  p_pd_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pwr_down) |-> $past(commit) && $past(frame_cmd) == 2'd0
                          && $past(frame_addr) == SF_CTRL);

  p_base_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ch_ofs) |-> $past(commit) && $past(frame_cmd) == 2'd0);

  p_rb_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && frame_cmd == 2'd0 && frame_addr == SF_RBSEL) |=> rb_pending);

  p_rb_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !(commit && frame_cmd == 2'd0 && frame_addr == SF_RBSEL))
      |=> !rb_pending);

  p_miso_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rb_pending |-> !miso);

endmodule

bind dac_spi_regs dac_spi_regs_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .commit     (commit),
  .frame_end  (frame_end),
  .frame_cmd  (frame.cmd),
  .frame_addr (frame.addr),
  .rb_pending (rb_pending),
  .miso       (spi_miso),
  .pwr_down   (pwr_down),
  .ch_code    (ch_code),
  .ch_ofs     (ch_offset_base)
);

// File: tb/dac_spi_regs_tb_top.sv
module dac_spi_regs_tb_top;

  localparam int NCH  = 12;
  localparam int GRP  = 4;
  localparam int NREF = 2;
  localparam int BITS = 14;
  localparam int KEEP = 16'hFFFF & ~((1 << (16 - BITS)) - 1);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, sclk, cs_n, mosi;
  wire  miso, pd;
  wire  [NCH*16-1:0] code;
  wire  [NCH*14-1:0] bofs;

  dac_spi_regs #(
    .NUM_CH     (NCH),
    .CH_PER_GRP (GRP),
    .NUM_REF    (NREF),
    .CODE_W     (BITS)
  ) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .spi_sclk       (sclk),
    .spi_cs_n       (cs_n),
    .spi_mosi       (mosi),
    .spi_miso       (miso),
    .pwr_down       (pd),
    .ch_code        (code),
    .ch_offset_base (bofs)
  );

  int    n_cmp  = 0;
  int    n_bad  = 0;
  int    settle = 0;
  string req    = "R11";

  int m_data [NCH];
  int m_ofs  [NCH];
  int m_gain [NCH];
  int m_gofs [3];
  int m_pd;
  int m_pend;
  int m_rbval;

  task automatic chk(string r, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", r, what, act, exp, $time);
    end
  endtask

  function automatic int grp(int ch);
    int g = ch / GRP;
    if (g > NREF - 1) g = NREF - 1;
    return g;
  endfunction

  task automatic compare_outputs();
    for (int ch = 0; ch < NCH; ch++) begin
      chk(req, "ch_code", int'(code[ch*16 +: 16]), m_data[ch]);
      chk(req, "ch_offset_base", int'(bofs[ch*14 +: 14]), m_gofs[grp(ch)]);
    end
    chk(req, "pwr_down", int'(pd), m_pd);
  endtask

  task automatic tick(int n);
    repeat (n) begin
      @(negedge clk);
      if (settle > 0) settle--;
      else if (rst_n) compare_outputs();
    end
  endtask

  function automatic int lookup(int t, int a);
    bit is_ch = (a >= 8) && (a < 8 + NCH);
    case (t)
      0, 1: return is_ch ? m_data[a-8] : 0;
      2:    return is_ch ? m_ofs[a-8]  : 0;
      3:    return is_ch ? m_gain[a-8] : 0;
      4: begin
        if (a == 1) return m_pd;
        if (a >= 2 && a < 2 + NREF) return m_gofs[a-2];
        return 0;
      end
      default: return 0;
    endcase
  endfunction

  function automatic void apply(logic [23:0] w, int nb);
    int c = int'(w[23:22]);
    int a = int'(w[21:16]);
    int d = int'(w[15:0]);
    bit is_ch = (a >= 8) && (a < 8 + NCH);
    m_pend = 0;
    if (nb != 24) return;
    case (c)
      3: if (is_ch) m_data[a-8] = d & KEEP;
      2: if (is_ch) m_ofs[a-8]  = d & KEEP;
      1: if (is_ch) m_gain[a-8] = d & KEEP;
      default: begin
        if (a == 1) m_pd = d & 1;
        else if (a >= 2 && a < 2 + NREF) m_gofs[a-2] = d & 16'h3FFF;
        else if (a == 5) begin
          m_pend  = 1;
          m_rbval = lookup((d >> 13) & 7, (d >> 7) & 63);
        end
      end
    endcase
  endfunction

  task automatic frame(logic [23:0] w, int nb);
    logic [23:0] resp;
    resp = (m_pend != 0) ? {8'h00, 16'(m_rbval)} : 24'h0;
    cs_n = 1'b0;
    tick(5);
    for (int k = 0; k < nb; k++) begin
      mosi = (k < 24) ? w[23-k] : 1'b0;
      tick(5);
      sclk = 1'b1;
      tick(5);
      chk(req, "miso", int'(miso), (k < 24) ? int'(resp[23-k]) : 0);
      sclk = 1'b0;
    end
    tick(5);
    cs_n = 1'b1;
    apply(w, nb);
    settle = 6;
    tick(8);
  endtask

  task automatic wr(int c, int a, int d);
    frame({2'(c), 6'(a), 16'(d)}, 24);
  endtask

  task automatic rb(int t, int a);
    frame({2'b00, 6'd5, 3'(t), 6'(a), 7'b0}, 24);
  endtask

  initial begin
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      m_data[i] = 0; m_ofs[i] = 0; m_gain[i] = KEEP;
    end
    for (int k = 0; k < 3; k++) m_gofs[k] = 0;
    m_pd = 0; m_pend = 0; m_rbval = 0;
    tick(5);
    rst_n = 1'b1;

    // R11: reset state at the outputs and through readback
    req = "R11";
    tick(3);
    rb(3, 8);
    rb(2, 9);
    rb(4, 1);
    rb(0, 19);
    wr(0, 0, 0);

    // R2: channel code writes with low-bit masking
    req = "R2";
    wr(3, 8, 'hABCD);
    wr(3, 19, 'h1237);
    rb(0, 8);
    wr(0, 0, 0);

    // R4: out-of-range channel addresses
    req = "R4";
    wr(3, 7, 'h5555);
    wr(3, 20, 'h5555);
    wr(2, 63, 'h0001);
    wr(1, 0, 'h0000);
    rb(0, 7);
    wr(0, 0, 0);

    // R3: offset and gain trims
    req = "R3";
    wr(2, 9, 'h1237);
    wr(1, 10, 'h8001);
    rb(2, 9);
    rb(3, 10);
    wr(0, 0, 0);

    // R5: power-down control bit
    req = "R5";
    wr(0, 1, 'hFFFE);
    wr(0, 1, 'h0001);
    rb(4, 1);
    wr(0, 0, 0);
    wr(0, 1, 'h0000);

    // R6: coarse offset registers, no-op and absent index
    req = "R6";
    wr(0, 2, 'hFFFF);
    wr(0, 3, 'h1555);
    wr(0, 4, 'h0AAA);
    wr(0, 0, 'hFFFF);
    rb(4, 2);
    rb(4, 4);
    wr(0, 0, 0);

    // R7: clamped group mapping for the upper channels
    req = "R7";
    wr(0, 3, 'h2001);
    wr(0, 2, 'h0123);

    // R1: wrong-length frames are discarded, correct one commits
    req = "R1";
    frame({2'd3, 6'd9, 16'hFFFF}, 23);
    frame({2'd3, 6'd9, 16'hFFFF}, 25);
    frame({2'd0, 6'd1, 16'h0001}, 1);
    wr(3, 9, 'h8421);

    // R9: readback source table
    req = "R9";
    rb(1, 19);
    rb(5, 8);
    rb(0, 30);
    rb(4, 7);
    rb(4, 3);
    wr(0, 0, 0);

    // R10: armed readback consumed by a short window
    req = "R10";
    rb(3, 8);
    frame({2'd0, 6'd0, 16'h0000}, 10);
    wr(0, 0, 0);
    rb(0, 19);
    frame({2'd3, 6'd8, 16'h00FF}, 30);
    wr(0, 0, 0);

    // R8: write and read back every channel in consecutive frames
    req = "R8";
    for (int i = 0; i < NCH; i++) wr(3, 8 + i, (i * 16'h1357 + 16'h0A0B) & 16'hFFFF);
    for (int i = 0; i < NCH; i++) rb(0, 8 + i);
    for (int i = 0; i < NCH; i++) wr(1, 8 + i, 16'hFFFF - i * 16'h0111);
    for (int i = 0; i < NCH; i++) rb(3, 8 + i);
    wr(0, 0, 0);

    tick(10);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired before the sequence completed");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad + 1);
    $finish;
  end

endmodule